// File: doc/BRIEF.md
# CPU interrupt and reset entry sequencer

This block sequences the bus cycles an 8-bit processor core runs at each instruction boundary. In the one-cycle boundary state it picks the next program: a reset entry, a non-maskable interrupt entry, a maskable interrupt entry or a plain opcode fetch. It then issues that program's memory cycles one at a time over a request/acknowledge bus. An entry program saves the return address and the status byte on the stack page and loads a new program counter from a fixed vector pair. The opcode decoder and the ALU sit outside. A stub fetch stands in for them: it reads one byte at the program counter and steps the counter.

The surrounding core supplies the architectural program counter, stack pointer and flags on `pc_in`, `sp_in` and `flags_in`. The sequencer copies them into working registers at the boundary where it chooses a program. When the program finishes, it presents the updated values on `pc_out`, `sp_out` and `flags_out` and raises `upd_valid` for one cycle, during the next boundary. `seq_mode` and `seq_step` report which program is running and which bus cycle it is on.

Top module: `cpu_entry_sequencer`

States of the controller: `ST_BOUNDARY` (no bus cycle; choose the program) goes to `ST_FETCH` when nothing is pending, and to `ST_DUMMY_A` otherwise. The entry chain runs `ST_DUMMY_A` → `ST_DUMMY_B` → `ST_PUSH_HI` → `ST_PUSH_LO` → `ST_PUSH_FL` → `ST_VEC_LO` → `ST_VEC_HI` → `ST_BOUNDARY`, and `ST_FETCH` returns to `ST_BOUNDARY`. Every state except the boundary moves on only in a cycle where `bus_ack` is high.

## Requirements
- R1: In each boundary cycle the program is chosen by priority: reset entry when `rst_req` is high or a power-on request is pending; otherwise NMI entry when an NMI request is latched or a falling edge of `nmi_n` arrives in that cycle; otherwise IRQ entry when `irq_n` is low and `flags_in` bit 2 is 0; otherwise a fetch.
- R2: Releasing `rst_n` leaves a power-on request pending, so the first program is a reset entry. Taking a reset entry clears that request, so the program after it is a fetch when no request is active.
- R3: A falling edge on `nmi_n` is latched and produces exactly one NMI entry, even if `nmi_n` stays low. The latched request is cleared when the NMI entry is taken, and it survives a reset entry that wins priority over it.
- R4: IRQ is level-sensitive and is never cleared by the sequencer: while `irq_n` is low and `flags_in` bit 2 is 0, every boundary chooses IRQ entry. When bit 2 is 1 the boundary chooses a fetch.
- R5: An IRQ or NMI entry issues seven bus cycles in this order: two reads at PC, a write of PC[15:8] to 0x0100+SP, a write of PC[7:0] to 0x0100+(SP-1), a write of the status byte to 0x0100+(SP-2), then a read of the vector low byte and a read of the vector high byte. `sp_out` equals SP-3 modulo 256, and every write targets addresses 0x0100–0x01FF.
- R6: In the pushed status byte, bit 5 is 1 and bit 4 is 0; every other bit equals `flags_in`.
- R7: A reset entry has the same seven-cycle shape and the same stack addresses. Its three stack cycles are reads (`bus_we` low), and it still leaves `sp_out` equal to SP-3.
- R8: Vector pairs (low byte, high byte): NMI 0xFFFA/0xFFFB, reset 0xFFFC/0xFFFD, IRQ 0xFFFE/0xFFFF. `pc_out` is {high byte, low byte}.
- R9: After the status push, an IRQ entry sets flags bit 2. NMI and reset entries set bit 2 and, when `CLR_DEC` is 1, clear bit 3.
- R10: A fetch issues one read at `pc_in`. It then gives `pc_out` = `pc_in`+1 and leaves `sp_out` = `sp_in` and `flags_out` = `flags_in`.
- R11: A bus cycle holds `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` steady until the cycle in which `bus_ack` is high; only then does the program advance.
- R12: `seq_mode` reads 0 for fetch, 1 for reset entry, 2 for IRQ entry and 3 for NMI entry. `seq_step` counts the bus cycles of an entry 0 to 6, and reads 0 for a fetch. `upd_valid` is high for exactly the one boundary cycle after a program completes, with no bus request in that cycle; `seq_mode` still names the completed program then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; arms the power-on request |
| rst_req | input | 1 | Reset request, level |
| nmi_n | input | 1 | Non-maskable interrupt, active low, edge-latched |
| irq_n | input | 1 | Maskable interrupt, active low, level |
| pc_in | input | 16 | Program counter from the core |
| sp_in | input | 8 | Stack pointer from the core |
| flags_in | input | 8 | Status byte from the core (bit 2 masks IRQ) |
| bus_req | output | 1 | A bus cycle is being requested |
| bus_addr | output | 16 | Bus address |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Completes the requested cycle in this clock |
| pc_out | output | 16 | Updated program counter |
| sp_out | output | 8 | Updated stack pointer |
| flags_out | output | 8 | Updated status byte |
| upd_valid | output | 1 | Updated values valid (one cycle) |
| seq_mode | output | 2 | Running program: 0 fetch, 1 reset, 2 IRQ, 3 NMI |
| seq_step | output | 3 | Bus cycle index within the program |

## Verification
The bench builds the block with its defaults: an 8-bit data path with 16-bit addresses, and `CLR_DEC` = 1. With 8-bit stack arithmetic, a stack pointer of 0x01 makes the push sequence wrap from 0x0100 to 0x01FF. The decimal-clearing flag step of NMI and reset entry is observable; the variant that keeps bit 3 is not built. A toggling acknowledge adds wait states to one entry, so stalled cycles and the stability rule are exercised alongside the normal single-cycle handshake.

// File: rtl/entry_seq_pkg.sv
package entry_seq_pkg;

    typedef enum logic [1:0] {
        MODE_FETCH = 2'd0,
        MODE_RESET = 2'd1,
        MODE_IRQ   = 2'd2,
        MODE_NMI   = 2'd3
    } seq_mode_e;

    typedef enum logic [3:0] {
        ST_BOUNDARY,
        ST_FETCH,
        ST_DUMMY_A,
        ST_DUMMY_B,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_FL,
        ST_VEC_LO,
        ST_VEC_HI
    } seq_state_e;

    // status byte bit positions
    localparam int FLAG_IMASK = 2;
    localparam int FLAG_DEC   = 3;
    localparam int FLAG_BRK   = 4;
    localparam int FLAG_ONE   = 5;

    localparam int STEP_W = 3;

endpackage

// File: rtl/entry_req_arbiter.sv
module entry_req_arbiter
    import entry_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rst_req,
    input  logic      nmi_n,
    input  logic      irq_n,
    input  logic      irq_masked,
    input  logic      take,
    output seq_mode_e choice
);

    logic nmi_q;
    logic nmi_pend;
    logic por_pend;
    logic nmi_edge;
    logic nmi_live;

    assign nmi_edge = nmi_q & ~nmi_n;
    assign nmi_live = nmi_pend | nmi_edge;

    // fixed priority: reset / power-on, NMI, unmasked IRQ, fetch
    always_comb begin
        if (rst_req || por_pend) begin
            choice = MODE_RESET;
        end else if (nmi_live) begin
            choice = MODE_NMI;
        end else if (!irq_n && !irq_masked) begin
            choice = MODE_IRQ;
        end else begin
            choice = MODE_FETCH;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q    <= 1'b1;
            nmi_pend <= 1'b0;
            por_pend <= 1'b1;
        end else begin
            nmi_q <= nmi_n;
            if (take && choice == MODE_NMI) begin
                nmi_pend <= 1'b0;
            end else begin
                nmi_pend <= nmi_live;
            end
            if (take && choice == MODE_RESET) begin
                por_pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/entry_seq_ctrl.sv
module entry_seq_ctrl
    import entry_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  seq_mode_e         choice,
    input  logic              bus_ack,
    output seq_state_e        state,
    output seq_mode_e         kind,
    output logic              bus_req,
    output logic              take,
    output logic              done,
    output logic [STEP_W-1:0] step
);

    seq_state_e state_q;
    seq_state_e state_d;
    seq_mode_e  kind_q;
    logic       done_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOUNDARY: state_d = (choice == MODE_FETCH) ? ST_FETCH : ST_DUMMY_A;
            ST_FETCH:    if (bus_ack) state_d = ST_BOUNDARY;
            ST_DUMMY_A:  if (bus_ack) state_d = ST_DUMMY_B;
            ST_DUMMY_B:  if (bus_ack) state_d = ST_PUSH_HI;
            ST_PUSH_HI:  if (bus_ack) state_d = ST_PUSH_LO;
            ST_PUSH_LO:  if (bus_ack) state_d = ST_PUSH_FL;
            ST_PUSH_FL:  if (bus_ack) state_d = ST_VEC_LO;
            ST_VEC_LO:   if (bus_ack) state_d = ST_VEC_HI;
            ST_VEC_HI:   if (bus_ack) state_d = ST_BOUNDARY;
            default:     state_d = ST_BOUNDARY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOUNDARY;
            kind_q  <= MODE_FETCH;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_BOUNDARY) begin
                kind_q <= choice;
            end
            done_q <= (state_q != ST_BOUNDARY) && (state_d == ST_BOUNDARY);
        end
    end

    // outputs
    always_comb begin
        bus_req = 1'b1;
        take    = 1'b0;
        step    = '0;
        unique case (state_q)
            ST_BOUNDARY: begin
                bus_req = 1'b0;
                take    = 1'b1;
            end
            ST_FETCH:   step = STEP_W'(0);
            ST_DUMMY_A: step = STEP_W'(0);
            ST_DUMMY_B: step = STEP_W'(1);
            ST_PUSH_HI: step = STEP_W'(2);
            ST_PUSH_LO: step = STEP_W'(3);
            ST_PUSH_FL: step = STEP_W'(4);
            ST_VEC_LO:  step = STEP_W'(5);
            ST_VEC_HI:  step = STEP_W'(6);
            default: begin
                bus_req = 1'b0;
            end
        endcase
    end

    assign state = state_q;
    assign kind  = kind_q;
    assign done  = done_q;

endmodule

// File: rtl/entry_seq_datapath.sv
module entry_seq_datapath
    import entry_seq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter bit CLR_DEC = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  seq_state_e            state,
    input  seq_mode_e             kind,
    input  logic                  bus_ack,
    input  logic [2*DATA_W-1:0]   pc_in,
    input  logic [DATA_W-1:0]     sp_in,
    input  logic [DATA_W-1:0]     flags_in,
    input  logic [DATA_W-1:0]     bus_rdata,
    output logic [2*DATA_W-1:0]   bus_addr,
    output logic                  bus_we,
    output logic [DATA_W-1:0]     bus_wdata,
    output logic [2*DATA_W-1:0]   pc_q,
    output logic [DATA_W-1:0]     sp_q,
    output logic [DATA_W-1:0]     fl_q
);

    localparam int AW = 2 * DATA_W;
    localparam logic [AW-1:0]     VEC_NMI   = {AW{1'b1}} - AW'(5);
    localparam logic [AW-1:0]     VEC_RST   = {AW{1'b1}} - AW'(3);
    localparam logic [AW-1:0]     VEC_IRQ   = {AW{1'b1}} - AW'(1);
    localparam logic [DATA_W-1:0] STK_PAGE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] BIT_IMASK = DATA_W'(1) << FLAG_IMASK;
    localparam logic [DATA_W-1:0] BIT_DEC   = DATA_W'(1) << FLAG_DEC;
    localparam logic [DATA_W-1:0] BIT_BRK   = DATA_W'(1) << FLAG_BRK;
    localparam logic [DATA_W-1:0] BIT_ONE   = DATA_W'(1) << FLAG_ONE;

    logic [AW-1:0]     vec_q;
    logic [AW-1:0]     vec_pick;
    logic [DATA_W-1:0] fl_after;
    logic [DATA_W-1:0] fl_pushed;
    logic [AW-1:0]     stk_addr;

    assign stk_addr  = {STK_PAGE, sp_q};
    assign fl_pushed = (fl_q | BIT_ONE) & ~BIT_BRK;

    always_comb begin
        unique case (kind)
            MODE_NMI:   vec_pick = VEC_NMI;
            MODE_RESET: vec_pick = VEC_RST;
            default:    vec_pick = VEC_IRQ;
        endcase
    end

    // flag step applied once the status byte has gone out
    generate
        if (CLR_DEC) begin : g_clear_dec
            always_comb begin
                if (kind == MODE_IRQ) begin
                    fl_after = fl_q | BIT_IMASK;
                end else begin
                    fl_after = (fl_q | BIT_IMASK) & ~BIT_DEC;
                end
            end
        end else begin : g_keep_dec
            always_comb begin
                fl_after = fl_q | BIT_IMASK;
            end
        end
    endgenerate

    // bus drive per state
    always_comb begin
        bus_addr  = pc_q;
        bus_we    = 1'b0;
        bus_wdata = '0;
        unique case (state)
            ST_BOUNDARY, ST_FETCH, ST_DUMMY_A, ST_DUMMY_B: begin
                bus_addr = pc_q;
            end
            ST_PUSH_HI: begin
                bus_addr  = stk_addr;
                bus_we    = (kind != MODE_RESET);
                bus_wdata = pc_q[AW-1:DATA_W];
            end
            ST_PUSH_LO: begin
                bus_addr  = stk_addr;
                bus_we    = (kind != MODE_RESET);
                bus_wdata = pc_q[DATA_W-1:0];
            end
            ST_PUSH_FL: begin
                bus_addr  = stk_addr;
                bus_we    = (kind != MODE_RESET);
                bus_wdata = fl_pushed;
            end
            ST_VEC_LO: bus_addr = vec_q;
            ST_VEC_HI: bus_addr = vec_q | AW'(1);
            default:   bus_addr = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            sp_q  <= '0;
            fl_q  <= '0;
            vec_q <= '0;
        end else if (state == ST_BOUNDARY) begin
            pc_q <= pc_in;
            sp_q <= sp_in;
            fl_q <= flags_in;
        end else if (bus_ack) begin
            case (state)
                ST_FETCH:   pc_q <= pc_q + AW'(1);
                ST_PUSH_HI: sp_q <= sp_q - DATA_W'(1);
                ST_PUSH_LO: begin
                    sp_q  <= sp_q - DATA_W'(1);
                    vec_q <= vec_pick;
                end
                ST_PUSH_FL: begin
                    sp_q <= sp_q - DATA_W'(1);
                    fl_q <= fl_after;
                end
                ST_VEC_LO:  pc_q[DATA_W-1:0]  <= bus_rdata;
                ST_VEC_HI:  pc_q[AW-1:DATA_W] <= bus_rdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cpu_entry_sequencer.sv
module cpu_entry_sequencer
    import entry_seq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter bit CLR_DEC = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rst_req,
    input  logic                nmi_n,
    input  logic                irq_n,
    input  logic [2*DATA_W-1:0] pc_in,
    input  logic [DATA_W-1:0]   sp_in,
    input  logic [DATA_W-1:0]   flags_in,
    output logic                bus_req,
    output logic [2*DATA_W-1:0] bus_addr,
    output logic                bus_we,
    output logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W-1:0]   bus_rdata,
    input  logic                bus_ack,
    output logic [2*DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0]   sp_out,
    output logic [DATA_W-1:0]   flags_out,
    output logic                upd_valid,
    output logic [1:0]          seq_mode,
    output logic [STEP_W-1:0]   seq_step
);

    seq_mode_e  choice;
    seq_mode_e  kind;
    seq_state_e state;
    logic       take;
    logic       done;

    entry_req_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_req    (rst_req),
        .nmi_n      (nmi_n),
        .irq_n      (irq_n),
        .irq_masked (flags_in[FLAG_IMASK]),
        .take       (take),
        .choice     (choice)
    );

    entry_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .choice  (choice),
        .bus_ack (bus_ack),
        .state   (state),
        .kind    (kind),
        .bus_req (bus_req),
        .take    (take),
        .done    (done),
        .step    (seq_step)
    );

    entry_seq_datapath #(
        .DATA_W  (DATA_W),
        .CLR_DEC (CLR_DEC)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .kind      (kind),
        .bus_ack   (bus_ack),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .flags_in  (flags_in),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .pc_q      (pc_out),
        .sp_q      (sp_out),
        .fl_q      (flags_out)
    );

    assign upd_valid = done;
    assign seq_mode  = kind;

endmodule

// File: rtl/entry_seq_checker.sv
module entry_seq_checker
    import entry_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_req,
    input logic                bus_ack,
    input logic [2*DATA_W-1:0] bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                upd_valid,
    input logic [1:0]          seq_mode,
    input logic [STEP_W-1:0]   seq_step
);

    localparam int AW = 2 * DATA_W;

    AST_WAIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R11

    AST_WRITE_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we |-> bus_addr[AW-1:DATA_W] == DATA_W'(1)); // R5

    AST_RESET_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && seq_mode == 2'd1 |-> !bus_we); // R7

    AST_FETCH_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && seq_mode == 2'd0 |-> !bus_we); // R10

    AST_UPD_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> !bus_req); // R12

    AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> !upd_valid); // R12

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_step <= STEP_W'(6)); // R12

endmodule

bind cpu_entry_sequencer entry_seq_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .upd_valid (upd_valid),
    .seq_mode  (seq_mode),
    .seq_step  (seq_step)
);

// File: tb/tb_cpu_entry_sequencer.sv
module tb_cpu_entry_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req = 1'b0;
    logic        nmi_n = 1'b1;
    logic        irq_n = 1'b1;
    logic [15:0] pc_in = 16'h0200;
    logic [7:0]  sp_in = 8'h00;
    logic [7:0]  flags_in = 8'h08;
    logic        bus_req;
    logic [15:0] bus_addr;
    logic        bus_we;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_ack;
    logic [15:0] pc_out;
    logic [7:0]  sp_out;
    logic [7:0]  flags_out;
    logic        upd_valid;
    logic [1:0]  seq_mode;
    logic [2:0]  seq_step;

    logic stall_en = 1'b0;
    logic tog = 1'b0;

    int checks = 0;
    int errors = 0;

    cpu_entry_sequencer dut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_n(nmi_n), .irq_n(irq_n),
        .pc_in(pc_in), .sp_in(sp_in), .flags_in(flags_in),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .pc_out(pc_out), .sp_out(sp_out), .flags_out(flags_out),
        .upd_valid(upd_valid), .seq_mode(seq_mode), .seq_step(seq_step)
    );

    always #5 clk = ~clk;

    always @(posedge clk) tog <= ~tog;
    assign bus_ack = bus_req & (tog | ~stall_en);

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        case (a)
            16'hFFFA: mem_byte = 8'h11;
            16'hFFFB: mem_byte = 8'h22;
            16'hFFFC: mem_byte = 8'h33;
            16'hFFFD: mem_byte = 8'h44;
            16'hFFFE: mem_byte = 8'h55;
            16'hFFFF: mem_byte = 8'h66;
            default:  mem_byte = a[7:0] ^ 8'hA5;
        endcase
    endfunction
    assign bus_rdata = mem_byte(bus_addr);

    // log of completed bus cycles
    logic [15:0] lg_addr [0:255];
    logic        lg_we   [0:255];
    logic [7:0]  lg_data [0:255];
    logic [2:0]  lg_step [0:255];
    logic [7:0]  lg_n = 8'd0;

    always @(posedge clk) begin
        if (rst_n && bus_req && bus_ack) begin
            lg_addr[lg_n] <= bus_addr;
            lg_we[lg_n]   <= bus_we;
            lg_data[lg_n] <= bus_wdata;
            lg_step[lg_n] <= seq_step;
            lg_n          <= lg_n + 8'd1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_upd();
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!upd_valid && n < 500);
        if (n >= 500) chk("R12", "no upd_valid", 32'd0, 32'd1);
    endtask

    task automatic check_entry(input logic [7:0] base, input logic [1:0] kind,
                               input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] fl);
        logic [15:0] vec;
        logic        wr;
        logic [7:0]  b;
        vec = (kind == 2'd3) ? 16'hFFFA : (kind == 2'd1) ? 16'hFFFC : 16'hFFFE;
        wr  = (kind != 2'd1);
        chk("R5", "entry cycle count", 32'(lg_n - base), 32'd7);
        for (int k = 0; k < 7; k++) begin
            b = base + 8'(k);
            chk("R12", "step index", 32'(lg_step[b]), 32'(k));
        end
        chk("R5", "dummy read 0 addr", 32'(lg_addr[base]), 32'(pc));
        chk("R5", "dummy read 1 addr", 32'(lg_addr[base + 8'd1]), 32'(pc));
        chk("R5", "dummy reads not writes", 32'({lg_we[base], lg_we[base + 8'd1]}), 32'd0);
        chk("R5", "stack addr 0", 32'(lg_addr[base + 8'd2]), 32'({8'h01, sp}));
        chk("R5", "stack addr 1", 32'(lg_addr[base + 8'd3]), 32'({8'h01, sp - 8'd1}));
        chk("R5", "stack addr 2", 32'(lg_addr[base + 8'd4]), 32'({8'h01, sp - 8'd2}));
        if (wr) begin
            chk("R5", "stack cycles write", 32'({lg_we[base + 8'd2], lg_we[base + 8'd3], lg_we[base + 8'd4]}), 32'd7);
            chk("R5", "pushed pc high", 32'(lg_data[base + 8'd2]), 32'(pc[15:8]));
            chk("R5", "pushed pc low", 32'(lg_data[base + 8'd3]), 32'(pc[7:0]));
            chk("R6", "pushed status", 32'(lg_data[base + 8'd4]), 32'((fl | 8'h20) & ~8'h10));
        end else begin
            chk("R7", "reset stack cycles read", 32'({lg_we[base + 8'd2], lg_we[base + 8'd3], lg_we[base + 8'd4]}), 32'd0);
        end
        chk("R8", "vector low addr", 32'(lg_addr[base + 8'd5]), 32'(vec));
        chk("R8", "vector high addr", 32'(lg_addr[base + 8'd6]), 32'(vec + 16'd1));
    endtask

    typedef struct packed {
        logic [1:0]  req;   // 0 none, 1 irq, 2 nmi, 3 reset request
        logic        stall;
        logic [15:0] pc;
        logic [7:0]  sp;
        logic [7:0]  fl;
        logic [1:0]  emode;
        logic [15:0] epc;
        logic [7:0]  esp;
        logic [7:0]  efl;
    } row_t;

    localparam row_t ROWS [6] = '{
        '{2'd0, 1'b0, 16'h1234, 8'hFD, 8'h24, 2'd0, 16'h1235, 8'hFD, 8'h24},  // R10 fetch
        '{2'd1, 1'b0, 16'h2000, 8'hFF, 8'h08, 2'd2, 16'h6655, 8'hFC, 8'h0C},  // R4 IRQ taken, R9
        '{2'd1, 1'b0, 16'h3000, 8'h80, 8'h04, 2'd0, 16'h3001, 8'h80, 8'h04},  // R4 IRQ masked
        '{2'd2, 1'b0, 16'h4080, 8'h01, 8'hD9, 2'd3, 16'h2211, 8'hFE, 8'hD5},  // R3 NMI, stack wrap
        '{2'd3, 1'b0, 16'h5555, 8'h40, 8'h0B, 2'd1, 16'h4433, 8'h3D, 8'h07},  // R7 reset request
        '{2'd1, 1'b1, 16'hABCD, 8'h10, 8'h00, 2'd2, 16'h6655, 8'h0D, 8'h04}   // R11 wait states
    };

    row_t       cur;
    logic [7:0] base;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R12 watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        chk("R12", "reset bus_req", 32'(bus_req), 32'd0);
        chk("R12", "reset upd_valid", 32'(upd_valid), 32'd0);
        chk("R12", "reset seq_mode", 32'(seq_mode), 32'd0);
        chk("R12", "reset seq_step", 32'(seq_step), 32'd0);

        // power-on entry
        base = lg_n;
        rst_n = 1'b1;
        wait_upd();
        chk("R2", "power-on program mode", 32'(seq_mode), 32'd1);
        chk("R8", "reset vector pc", 32'(pc_out), 32'h4433);
        chk("R7", "reset sp", 32'(sp_out), 32'hFD);
        chk("R9", "reset flags", 32'(flags_out), 32'h04);
        check_entry(base, 2'd1, 16'h0200, 8'h00, 8'h08);

        // table of vectors
        for (int i = 0; i < 6; i++) begin
            cur      = ROWS[i];
            pc_in    = cur.pc;
            sp_in    = cur.sp;
            flags_in = cur.fl;
            stall_en = cur.stall;
            irq_n    = !(cur.req == 2'd1);
            nmi_n    = !(cur.req == 2'd2);
            rst_req  = (cur.req == 2'd3);
            base     = lg_n;
            wait_upd();
            chk("R1", "row mode", 32'(seq_mode), 32'(cur.emode));
            chk("R8", "row pc_out", 32'(pc_out), 32'(cur.epc));
            chk("R5", "row sp_out", 32'(sp_out), 32'(cur.esp));
            chk("R9", "row flags_out", 32'(flags_out), 32'(cur.efl));
            if (cur.emode == 2'd0) begin
                chk("R10", "fetch cycle count", 32'(lg_n - base), 32'd1);
                chk("R10", "fetch addr", 32'(lg_addr[base]), 32'(cur.pc));
                chk("R10", "fetch is read", 32'(lg_we[base]), 32'd0);
            end else begin
                check_entry(base, cur.emode, cur.pc, cur.sp, cur.fl);
            end
            irq_n    = 1'b1;
            nmi_n    = 1'b1;
            rst_req  = 1'b0;
            stall_en = 1'b0;
        end

        pc_in    = 16'h0300;
        sp_in    = 8'hF0;
        flags_in = 8'h00;

        // NMI held low gives one entry only
        nmi_n = 1'b0;
        wait_upd();
        chk("R3", "nmi first entry", 32'(seq_mode), 32'd3);
        wait_upd();
        chk("R3", "nmi held low no second entry", 32'(seq_mode), 32'd0);
        nmi_n = 1'b1;
        wait_upd();
        chk("R3", "nmi rising edge ignored", 32'(seq_mode), 32'd0);

        // IRQ level stays active
        irq_n = 1'b0;
        wait_upd();
        chk("R4", "irq level first", 32'(seq_mode), 32'd2);
        wait_upd();
        chk("R4", "irq level again", 32'(seq_mode), 32'd2);
        irq_n = 1'b1;
        wait_upd();
        chk("R4", "irq released", 32'(seq_mode), 32'd0);

        // reset beats NMI; NMI kept pending
        rst_req = 1'b1;
        nmi_n   = 1'b0;
        wait_upd();
        chk("R1", "reset over nmi", 32'(seq_mode), 32'd1);
        rst_req = 1'b0;
        wait_upd();
        chk("R3", "nmi kept across reset", 32'(seq_mode), 32'd3);
        nmi_n = 1'b1;
        wait_upd();
        chk("R3", "nmi consumed", 32'(seq_mode), 32'd0);

        // NMI beats IRQ
        nmi_n = 1'b0;
        irq_n = 1'b0;
        wait_upd();
        chk("R1", "nmi over irq", 32'(seq_mode), 32'd3);
        nmi_n = 1'b1;
        irq_n = 1'b1;
        wait_upd();
        chk("R1", "idle after nmi", 32'(seq_mode), 32'd0);

        // rst_n mid-run re-arms power-on
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2", "mid-run reset bus_req", 32'(bus_req), 32'd0);
        chk("R2", "mid-run reset upd_valid", 32'(upd_valid), 32'd0);
        rst_n = 1'b1;
        wait_upd();
        chk("R2", "power-on again", 32'(seq_mode), 32'd1);
        wait_upd();
        chk("R2", "power-on cleared", 32'(seq_mode), 32'd0);
        chk("R10", "fetch pc after reset", 32'(pc_out), 32'h0301);

        summary();
        $finish;
    end

endmodule